// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small fully associative store that remembers, for recently taken branches, the instruction words sitting at each branch's target. When fetch meets a branch predicted taken, it presents the branch PC on the lookup port. On a hit, the block returns up to four sequential target instructions, so the decoder can be fed at once while the ordinary fetch path fetches the rest of the target stream. This removes the bubbles that would otherwise follow the taken branch.

Entries are written only when a taken branch resolves. The allocate port carries the branch PC, the target words and how many of them are usable. A target close to the end of a fetch block may yield fewer than four words. A single invalidate input empties the whole store at once, for instance after code has been modified.

Each entry is tagged with the full word address of the branch. An allocation to a PC already held rewrites that entry. Otherwise the allocation takes the lowest-numbered empty entry. When no entry is empty, a round-robin pointer picks the victim.

Top module: `tgt_insn_cache`

## Requirements
- R1: After reset every entry is empty: no lookup hits, and `lk_hit`, `lk_cnt` and `lk_words` are zero.
- R2: A lookup presented with `lk_valid` high at a clock edge gives its result on the outputs right after that edge. The result is a hit when an entry with a tag equal to `lk_pc` is valid, and a miss otherwise.
- R3: `al_cnt` encodes the number of usable words minus one, so 0 means 1 word and 3 means 4 words. A hit reports that number (1 to 4) on `lk_cnt`. `lk_words` holds the first target word in bits [31:0], the next in [63:32], and so on. Word slots beyond the usable count read as zero.
- R4: In any cycle after an edge without a lookup, and after any miss, `lk_hit`, `lk_cnt` and `lk_words` are all zero.
- R5: An allocation whose PC matches a valid entry rewrites that entry in place. Only the new words and count are returned afterwards, and no second copy is made.
- R6: An allocation for a new PC fills the lowest-numbered empty entry while any entry is empty.
- R7: When all entries are full, a new PC replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such a replacement.
- R8: `inv_all` empties every entry at the clock edge where it is high. A lookup in the following cycle misses.
- R9: When `inv_all` and `al_valid` are high in the same cycle, the invalidate wins and the allocation is dropped.
- R10: A lookup and an allocation in the same cycle: the lookup sees the contents from before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Word address of the branch being looked up |
| lk_hit | output | 1 | Lookup hit, registered |
| lk_cnt | output | clog2(WORDS+1) | Usable words returned (1..WORDS), zero on miss |
| lk_words | output | WORDS*INSN_W | Target instructions, first word in lowest bits |
| al_valid | input | 1 | Allocate request for a resolved taken branch |
| al_pc | input | PC_W | Word address of the taken branch |
| al_cnt | input | clog2(WORDS) | Usable words minus one |
| al_words | input | WORDS*INSN_W | Target instructions, first word in lowest bits |
| inv_all | input | 1 | Empty every entry |

## Verification
Every lookup result is due exactly one clock after the edge at which the lookup was presented. It reflects the store as it stood before that edge's allocate or invalidate takes effect. The bench drives each vector at a falling edge and computes the expected result from its own model in that cycle, before it applies the update. It compares the outputs at the next falling edge, after exactly one rising edge. An invalidate or allocate therefore becomes visible to a lookup presented in the next cycle, with its result two edges after the update. The directed sequences place lookups at those exact offsets.

// File: rtl/tgt_insn_cache.sv
module tgt_insn_cache #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 30,
  parameter int INSN_W  = 32,
  parameter int WORDS   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  input  logic [PC_W-1:0]           lk_pc,
  output logic                      lk_hit,
  output logic [$clog2(WORDS+1)-1:0] lk_cnt,
  output logic [WORDS*INSN_W-1:0]   lk_words,
  input  logic                      al_valid,
  input  logic [PC_W-1:0]           al_pc,
  input  logic [$clog2(WORDS)-1:0]  al_cnt,
  input  logic [WORDS*INSN_W-1:0]   al_words,
  input  logic                      inv_all
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(WORDS);
  localparam int OCNT_W = $clog2(WORDS+1);
  localparam int LINE_W = WORDS*INSN_W;

  logic [ENTRIES-1:0] vld;
  logic [PC_W-1:0]    tag  [ENTRIES];
  logic [CNT_W-1:0]   cnt  [ENTRIES];
  logic [LINE_W-1:0]  line [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] lk_m, al_m;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_m[i] = vld[i] && (tag[i] == lk_pc);
    assign al_m[i] = vld[i] && (tag[i] == al_pc);
  end

  logic [LINE_W-1:0] sel_line;
  logic [CNT_W-1:0]  sel_cnt;
  always_comb begin
    sel_line = '0;
    sel_cnt  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_line |= line[i] & {LINE_W{lk_m[i]}};
      sel_cnt  |= cnt[i]  & {CNT_W{lk_m[i]}};
    end
  end

  logic [IDX_W-1:0] hit_idx, free_idx, vic_idx;
  logic             use_rr;
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (al_m[i]) hit_idx  = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end
  assign use_rr  = !(|al_m) && (&vld);
  assign vic_idx = (|al_m) ? hit_idx : (use_rr ? rr : free_idx);

  wire do_alloc = al_valid && !inv_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else if (al_valid) begin
      vld[vic_idx] <= 1'b1;
      if (use_rr) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tag[vic_idx]  <= al_pc;
      cnt[vic_idx]  <= al_cnt;
      line[vic_idx] <= al_words;
    end
  end

  logic [LINE_W-1:0] masked;
  for (genvar w = 0; w < WORDS; w++) begin : g_mask
    assign masked[w*INSN_W +: INSN_W] =
      (w <= int'(sel_cnt)) ? sel_line[w*INSN_W +: INSN_W] : '0;
  end

  wire hit_n = lk_valid && (|lk_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit   <= 1'b0;
      lk_cnt   <= '0;
      lk_words <= '0;
    end else begin
      lk_hit   <= hit_n;
      lk_cnt   <= hit_n ? OCNT_W'(sel_cnt) + 1'b1 : '0;
      lk_words <= hit_n ? masked : '0;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_m)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_cnt >= 1 && lk_cnt <= OCNT_W'(WORDS))); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_cnt == '0 && lk_words == '0)); // R4
  AST_NO_REQ_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit); // R2
  AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !$isunknown(lk_pc)) ##1 lk_valid |=> !lk_hit); // R8
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !do_alloc |=> $stable(rr)); // R7
endmodule

// File: tb/test_tgt_insn_cache.sv
`timescale 1ns/1ps
module test_tgt_insn_cache;
  localparam int ENTRIES = 64;
  localparam int PC_W    = 30;
  localparam int INSN_W  = 32;
  localparam int WORDS   = 4;
  localparam int LINE_W  = WORDS*INSN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, al_valid = 1'b0, inv_all = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, al_pc = '0;
  logic [1:0] al_cnt = '0;
  logic [LINE_W-1:0] al_words = '0;
  logic lk_hit;
  logic [2:0] lk_cnt;
  logic [LINE_W-1:0] lk_words;

  always #5 clk = ~clk;

  tgt_insn_cache #(.ENTRIES(ENTRIES), .PC_W(PC_W), .INSN_W(INSN_W), .WORDS(WORDS)) i_tgt_insn_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_cnt(lk_cnt), .lk_words(lk_words), .al_valid(al_valid), .al_pc(al_pc),
    .al_cnt(al_cnt), .al_words(al_words), .inv_all(inv_all));

  int vectors = 0, errors = 0;

  logic            m_v   [ENTRIES];
  logic [PC_W-1:0] m_tag [ENTRIES];
  logic [1:0]      m_c   [ENTRIES];
  logic [LINE_W-1:0] m_w [ENTRIES];
  int m_rr = 0;

  logic e_hit = 1'b0;
  logic [2:0] e_cnt = '0;
  logic [LINE_W-1:0] e_words = '0;
  string e_tag = "R1";

  function automatic logic [LINE_W-1:0] rnd_line();
    logic [LINE_W-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*INSN_W +: INSN_W] = $urandom;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] mask_line(logic [LINE_W-1:0] l, int n);
    logic [LINE_W-1:0] r = '0;
    for (int k = 0; k < n; k++) r[k*INSN_W +: INSN_W] = l[k*INSN_W +: INSN_W];
    return r;
  endfunction

  function automatic void model_lookup(logic v, logic [PC_W-1:0] pc);
    e_hit = 1'b0; e_cnt = '0; e_words = '0;
    if (!v) return;
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && m_tag[i] == pc) begin
        e_hit = 1'b1;
        e_cnt = 3'(m_c[i]) + 3'd1;
        e_words = mask_line(m_w[i], int'(m_c[i]) + 1);
      end
  endfunction

  function automatic void model_update(logic a, logic [PC_W-1:0] pc, logic [1:0] c,
                                       logic [LINE_W-1:0] w, logic inv);
    int idx = -1;
    if (inv) begin
      for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
      return;
    end
    if (!a) return;
    for (int i = 0; i < ENTRIES; i++) if (idx < 0 && m_v[i] && m_tag[i] == pc) idx = i;
    if (idx < 0) for (int i = 0; i < ENTRIES; i++) if (idx < 0 && !m_v[i]) idx = i;
    if (idx < 0) begin
      idx = m_rr;
      m_rr = (m_rr + 1) % ENTRIES;
    end
    m_v[idx] = 1'b1; m_tag[idx] = pc; m_c[idx] = c; m_w[idx] = w;
  endfunction

  task automatic check_prev();
    vectors++;
    if (lk_hit !== e_hit || lk_cnt !== e_cnt || lk_words !== e_words) begin
      errors++;
      $display("FAIL %s: hit=%0b cnt=%0d words=%h expected hit=%0b cnt=%0d words=%h",
               e_tag, lk_hit, lk_cnt, lk_words, e_hit, e_cnt, e_words);
    end
  endtask

  task automatic step(input logic lv, input logic [PC_W-1:0] lp, input logic av,
                      input logic [PC_W-1:0] ap, input logic [1:0] ac,
                      input logic [LINE_W-1:0] aw, input logic inv, input string tg);
    @(negedge clk);
    check_prev();
    lk_valid = lv; lk_pc = lp; al_valid = av; al_pc = ap; al_cnt = ac; al_words = aw;
    inv_all = inv;
    e_tag = tg;
    model_lookup(lv, lp);
    model_update(av, ap, ac, aw, inv);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] wa, wb;
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < ENTRIES; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_c[i] = '0; m_w[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: outputs zero after reset, lookup of any pc misses
    step(1, 30'd0, 0, 0, 0, 0, 0, "R1");
    step(1, 30'd5, 0, 0, 0, 0, 0, "R1");
    // R3: two usable words, upper slots zero
    wa = rnd_line();
    step(0, 0, 1, 30'd5, 2'd1, wa, 0, "R4");
    step(1, 30'd5, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, "R3");
    // R10: lookup alongside rewrite sees old words; R5: afterwards sees new ones
    wb = rnd_line();
    step(1, 30'd5, 1, 30'd5, 2'd3, wb, 0, "R10");
    step(1, 30'd5, 0, 0, 0, 0, 0, "R5");
    step(1, 30'd6, 0, 0, 0, 0, 0, "R2");
    // R6: fill remaining entries in order
    for (int i = 1; i < ENTRIES; i++) step(0, 0, 1, 30'(1000 + i), 2'(i), rnd_line(), 0, "R6");
    step(1, 30'd1001, 0, 0, 0, 0, 0, "R6");
    step(1, 30'(1000 + ENTRIES - 1), 0, 0, 0, 0, 0, "R6");
    // R7: full store, new pc replaces entry 0 (pc 5), then entry 1
    step(1, 30'd5, 1, 30'd77, 2'd2, rnd_line(), 0, "R7");
    step(1, 30'd5, 1, 30'd78, 2'd0, rnd_line(), 0, "R7");
    step(1, 30'd1001, 0, 0, 0, 0, 0, "R7");
    step(1, 30'd77, 0, 0, 0, 0, 0, "R7");
    // R9: invalidate beats allocate
    step(0, 0, 1, 30'd9, 2'd3, rnd_line(), 1, "R9");
    step(1, 30'd9, 0, 0, 0, 0, 0, "R9");
    step(1, 30'd78, 0, 0, 0, 0, 0, "R8");
    // R8: refill then invalidate, lookup next cycle misses
    step(0, 0, 1, 30'd40, 2'd3, rnd_line(), 0, "R8");
    step(1, 30'd40, 0, 0, 0, 0, 1, "R8");
    step(1, 30'd40, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic lv, av, iv;
      lv = ($urandom % 10) < 7;
      av = ($urandom % 10) < 4;
      iv = ($urandom % 200) == 0;
      step(lv, 30'($urandom % 90), av, 30'($urandom % 90), 2'($urandom),
           rnd_line(), iv, "R2");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    @(negedge clk);
    check_prev();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule